// File: doc/BRIEF.md
# Multi-Exposure Linear Wide-Range Pixel Combiner

This block takes four digitized samples of one pixel, each captured with a different accumulation time, and fuses them into one linear word covering a much wider illumination range than a single sample. The accumulation times are long, short, very short and extremely short. Each shorter time is a fixed fraction of the one before it, with factors 10, 12 and 12. A sample from the short exposure is therefore worth 10 long-exposure units, a very-short sample 120, and an extremely-short sample 1440.

Samples arrive one per cycle at most. Each carries a 12-bit unsigned code, a valid strobe and a 2-bit exposure tag, and the four samples of a pixel may come in any order. Once all four tags of a pixel have been collected, the block picks the longest exposure whose code is below the saturation level. It multiplies that code by the gain of its exposure and emits a 23-bit linear word, together with the tag of the exposure that was chosen. The result stays proportional to light across the whole range, with no compressive segment. Tone mapping of the wide word is done downstream.

Top module: `mexp_combiner`

## Requirements
- R1: After a cycle with `rst_n` low, `out_valid` and `err_dup` are 0 until new samples are accepted.
- R2: Tags are encoded as 0 = long, 1 = short, 2 = very short, 3 = extremely short. Samples of a pixel may arrive in any tag order. A pixel is emitted only once all four tags have been accepted. `out_valid` is a one-cycle pulse that is visible after the second rising edge following the edge that accepted the fourth tag.
- R3: The chosen exposure is the first one, in the order long, short, very short, extremely short, whose code is strictly below `sat_level`.
- R4: A code equal to `sat_level` counts as saturated. The threshold is a live input, and systems normally drive it to 4000.
- R5: When all four codes are saturated, the extremely-short sample is used and `out_sel` is 3.
- R6: `out_value` equals the chosen code multiplied by 1, 10, 120 or 1440 for tags 0, 1, 2 or 3, and `out_sel` carries that tag. The full product 4095 × 1440 fits without loss.
- R7: A sample whose tag was already accepted for the current pixel raises `err_dup` for one cycle, visible after the edge that saw it. That sample is discarded, and the first sample with that tag is kept.
- R8: The first sample of the next pixel may be accepted on the edge right after the edge that completed the previous pixel, and the two pixels do not disturb each other.
- R9: Cycles with `in_valid` low have no effect, whatever `in_tag` and `in_code` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A sample is offered this cycle |
| in_tag | input | 2 | Exposure of the offered sample (0 long … 3 extremely short) |
| in_code | input | 12 | Unsigned converter code of the sample |
| sat_level | input | 12 | Codes at or above this value are saturated |
| out_valid | output | 1 | One-cycle strobe for a merged pixel |
| out_value | output | 23 | Linear merged value in long-exposure units |
| out_sel | output | 2 | Tag of the exposure that was used |
| err_dup | output | 1 | One-cycle strobe for a repeated tag within a pixel |

## Verification
The emission of a finished pixel and the duplicate-tag error of the next pixel can land in the same cycle. The bench provokes this by completing one pixel and then, on the two following edges, offering the same tag twice for the next pixel. At the sample point after the second of those edges, it requires both `out_valid` and `err_dup` high, with the first pixel's value intact. It then finishes the second pixel and checks that the discarded duplicate did not replace the first sample with that tag.

// File: rtl/mexp_pkg.sv
// Shared constants for the multi-exposure combiner.
// Assumes exactly four exposures, tagged by index in order of decreasing accumulation time.
package mexp_pkg;
    localparam int unsigned LANES  = 4;
    localparam int unsigned TAG_W  = $clog2(LANES);
    localparam int unsigned CODE_W = 12;

    typedef enum logic [TAG_W-1:0] {
        EXP_LONG   = 2'd0,
        EXP_SHORT  = 2'd1,
        EXP_VSHORT = 2'd2,
        EXP_XSHORT = 2'd3
    } exp_tag_t;
endpackage

// File: rtl/mexp_collect.sv
// Gathers the four exposure samples of one pixel into a bank, tracking which tags have arrived.
// Produces a one-cycle done strobe when the set is complete, and flags repeated tags (the repeat is dropped).
// Assumes at most one sample per cycle. The bank stays stable for one cycle after done, which is enough for the next stage.
module mexp_collect #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned CODE_W = 12,
    localparam int unsigned TAG_W = $clog2(LANES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [TAG_W-1:0]             in_tag,
    input  logic [CODE_W-1:0]            in_code,
    output logic [LANES-1:0][CODE_W-1:0] bank,
    output logic                         done,
    output logic                         dup
);
    logic [LANES-1:0] seen;
    logic [LANES-1:0] tag_hot;
    logic             fresh;

    // Decode the incoming tag and decide whether it is new for this pixel.
    always_comb begin
        tag_hot = LANES'(1) << in_tag;
        fresh   = in_valid && ((seen & tag_hot) == '0);
    end

    // One storage lane per exposure, written only by the first sample with its tag.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank[g] <= '0;
            else if (fresh && tag_hot[g])
                bank[g] <= in_code;
        end
    end

    // Track arrived tags, close the pixel when all are present, and strobe errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
            done <= 1'b0;
            dup  <= 1'b0;
        end else begin
            dup  <= in_valid && !fresh;
            done <= 1'b0;
            if (fresh) begin
                if ((seen | tag_hot) == {LANES{1'b1}}) begin
                    seen <= '0;
                    done <= 1'b1;
                end else begin
                    seen <= seen | tag_hot;
                end
            end
        end
    end
endmodule

// File: rtl/mexp_pick.sv
// Chooses the longest exposure whose code lies below the saturation level, falling back to the shortest.
// Registers the chosen code and tag. Assumes lane index 0 is the longest accumulation time.
module mexp_pick #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned CODE_W = 12,
    localparam int unsigned TAG_W = $clog2(LANES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go,
    input  logic [LANES-1:0][CODE_W-1:0] bank,
    input  logic [CODE_W-1:0]            sat_level,
    output logic                         pick_valid,
    output logic [CODE_W-1:0]            pick_code,
    output logic [TAG_W-1:0]             pick_tag
);
    logic [TAG_W-1:0] sel;
    logic             found;

    // Priority scan from longest to shortest exposure.
    always_comb begin
        sel   = TAG_W'(LANES - 1);
        found = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (!found && (bank[i] < sat_level)) begin
                sel   = TAG_W'(i);
                found = 1'b1;
            end
        end
    end

    // Capture the choice on the cycle after the pixel completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_valid <= 1'b0;
            pick_code  <= '0;
            pick_tag   <= '0;
        end else begin
            pick_valid <= go;
            if (go) begin
                pick_code <= bank[sel];
                pick_tag  <= sel;
            end
        end
    end
endmodule

// File: rtl/mexp_scale.sv
// Multiplies the chosen code by the cumulative accumulation-time gain of its exposure and registers the result.
// Gains are the running products of the per-step ratios. Assumes OUT_W holds the largest code times the largest gain.
module mexp_scale #(
    parameter int unsigned CODE_W  = 12,
    parameter int unsigned TAG_W   = 2,
    parameter int unsigned RATIO_1 = 10,
    parameter int unsigned RATIO_2 = 12,
    parameter int unsigned RATIO_3 = 12,
    parameter int unsigned OUT_W   = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_value,
    output logic [TAG_W-1:0]  out_sel
);
    localparam logic [OUT_W-1:0] GAIN_1 = OUT_W'(RATIO_1);
    localparam logic [OUT_W-1:0] GAIN_2 = OUT_W'(RATIO_1 * RATIO_2);
    localparam logic [OUT_W-1:0] GAIN_3 = OUT_W'(RATIO_1 * RATIO_2 * RATIO_3);

    logic [OUT_W-1:0] gain;

    // Look up the gain for the chosen exposure.
    always_comb begin
        case (in_tag)
            TAG_W'(0): gain = OUT_W'(1);
            TAG_W'(1): gain = GAIN_1;
            TAG_W'(2): gain = GAIN_2;
            default:   gain = GAIN_3;
        endcase
    end

    // Register the linear product and the tag that produced it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_sel   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_value <= OUT_W'(in_code) * gain;
                out_sel   <= in_tag;
            end
        end
    end
endmodule

// File: rtl/mexp_combiner.sv
// Top level: collects four exposure samples per pixel, picks the longest unsaturated one, and scales it to a linear word.
// Latency is two edges from the edge that accepts the final tag. Assumes at most one input sample per cycle.
module mexp_combiner #(
    parameter int unsigned RATIO_1 = 10,
    parameter int unsigned RATIO_2 = 12,
    parameter int unsigned RATIO_3 = 12,
    localparam int unsigned CODE_W = mexp_pkg::CODE_W,
    localparam int unsigned TAG_W  = mexp_pkg::TAG_W,
    localparam int unsigned LANES  = mexp_pkg::LANES,
    localparam int unsigned OUT_W  =
        $clog2(((1 << CODE_W) - 1) * RATIO_1 * RATIO_2 * RATIO_3 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [CODE_W-1:0] in_code,
    input  logic [CODE_W-1:0] sat_level,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_value,
    output logic [TAG_W-1:0]  out_sel,
    output logic              err_dup
);
    logic [LANES-1:0][CODE_W-1:0] bank;
    logic                         done;
    logic                         pick_valid;
    logic [CODE_W-1:0]            pick_code;
    logic [TAG_W-1:0]             pick_tag;

    mexp_collect #(.LANES(LANES), .CODE_W(CODE_W)) u_collect (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_code(in_code), .bank(bank), .done(done), .dup(err_dup)
    );

    mexp_pick #(.LANES(LANES), .CODE_W(CODE_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .go(done), .bank(bank), .sat_level(sat_level),
        .pick_valid(pick_valid), .pick_code(pick_code), .pick_tag(pick_tag)
    );

    mexp_scale #(
        .CODE_W(CODE_W), .TAG_W(TAG_W), .RATIO_1(RATIO_1),
        .RATIO_2(RATIO_2), .RATIO_3(RATIO_3), .OUT_W(OUT_W)
    ) u_scale (
        .clk(clk), .rst_n(rst_n), .in_valid(pick_valid), .in_code(pick_code),
        .in_tag(pick_tag), .out_valid(out_valid), .out_value(out_value),
        .out_sel(out_sel)
    );
endmodule

// File: rtl/mexp_combiner_chk.sv
// Assertion checker for the combiner, attached through bind. It observes ports only.
module mexp_combiner_chk #(
    parameter int unsigned OUT_W = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_value,
    input logic [1:0]       out_sel,
    input logic             err_dup
);
    // A pixel needs four accepted samples, so two strobes can never be adjacent.
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // The long exposure is used unscaled, so its value fits the code range.
    p_long_unscaled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sel == 2'd0) |-> (out_value < 4096));

    // Scaled exposures produce multiples of their gain.
    p_short_gain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sel == 2'd1) |-> (out_value % 10 == 0));

    p_xshort_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sel == 2'd3) |-> (out_value % 1440 == 0));

    // An error strobe must stem from a sample offered on the previous edge.
    p_dup_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_dup |-> $past(in_valid));
endmodule

bind mexp_combiner mexp_combiner_chk #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_value(out_value), .out_sel(out_sel), .err_dup(err_dup)
);

// File: tb/mexp_combiner_test.sv
`timescale 1ns/1ps
// Directed bench for the combiner: one task per scenario, each task checking its own results.
module mexp_combiner_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_tag;
    logic [11:0] in_code;
    logic [11:0] sat_level;
    logic        out_valid;
    logic [22:0] out_value;
    logic [1:0]  out_sel;
    logic        err_dup;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    mexp_combiner uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_code(in_code), .sat_level(sat_level), .out_valid(out_valid),
        .out_value(out_value), .out_sel(out_sel), .err_dup(err_dup)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model written from R3..R6.
    function automatic void model(input logic [11:0] c [4], input logic [11:0] sat,
                                  output longint val, output int sel);
        longint gains [4] = '{1, 10, 120, 1440};
        sel = 3;
        for (int i = 3; i >= 0; i--) if (c[i] < sat) sel = i;
        val = longint'(c[sel]) * gains[sel];
    endfunction

    // Offer one sample; returns at the falling edge after the accepting edge.
    task automatic send(input logic [1:0] tag, input logic [11:0] code);
        in_valid = 1'b1; in_tag = tag; in_code = code;
        @(negedge clk);
        in_valid = 1'b0; in_tag = ~tag; in_code = ~code;
    endtask

    // Called right after the final send: checks the one-cycle gap, then the strobe.
    task automatic expect_out(input string req, input logic [11:0] c [4]);
        longint v; int s;
        model(c, sat_level, v, s);
        @(negedge clk);
        chk(req, "out_valid one edge early", out_valid, 0);
        @(negedge clk);
        chk(req, "out_valid", out_valid, 1);
        chk(req, "out_value", out_value, v);
        chk(req, "out_sel", out_sel, s);
        @(negedge clk);
        chk(req, "out_valid single pulse", out_valid, 0);
    endtask

    task automatic pixel(input string req, input logic [11:0] c [4], input int ord [4]);
        for (int i = 0; i < 4; i++) send(2'(ord[i]), c[ord[i]]);
        expect_out(req, c);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_tag = '0; in_code = '0; sat_level = 12'd4000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "out_valid after reset", out_valid, 0);
        chk("R1", "err_dup after reset", err_dup, 0);
    endtask

    task automatic t_select();
        int o [4] = '{0, 1, 2, 3};
        pixel("R3", '{12'd1234, 12'd200, 12'd30, 12'd2}, o);
        pixel("R3", '{12'd4095, 12'd3999, 12'd400, 12'd33}, o);
        pixel("R3", '{12'd4001, 12'd4050, 12'd2500, 12'd210}, o);
        pixel("R6", '{12'd4095, 12'd4095, 12'd4095, 12'd4095}, o);
    endtask

    task automatic t_order();
        int o1 [4] = '{3, 1, 0, 2};
        int o2 [4] = '{2, 3, 1, 0};
        pixel("R2", '{12'd4000, 12'd3000, 12'd250, 12'd20}, o1);
        pixel("R2", '{12'd4080, 12'd4010, 12'd4020, 12'd347}, o2);
    endtask

    task automatic t_threshold();
        int o [4] = '{0, 1, 2, 3};
        pixel("R4", '{12'd4000, 12'd3999, 12'd1, 12'd1}, o);
        sat_level = 12'd1000;
        pixel("R4", '{12'd1000, 12'd999, 12'd5, 12'd0}, o);
        pixel("R5", '{12'd1000, 12'd1500, 12'd3000, 12'd1007}, o);
        sat_level = 12'd4000;
    endtask

    task automatic t_gaps();
        logic [11:0] c [4] = '{12'd4090, 12'd3333, 12'd77, 12'd9};
        send(2'd1, c[1]);
        in_tag = 2'd0; in_code = 12'd5;
        repeat (3) @(negedge clk);
        chk("R9", "no output while idle", out_valid, 0);
        send(2'd0, c[0]);
        in_tag = 2'd3; in_code = 12'd11;
        repeat (2) @(negedge clk);
        send(2'd3, c[3]);
        send(2'd2, c[2]);
        expect_out("R9", c);
    endtask

    task automatic t_dup();
        logic [11:0] c [4] = '{12'd600, 12'd10, 12'd1, 12'd0};
        send(2'd0, c[0]);
        chk("R7", "no error on first tag", err_dup, 0);
        send(2'd0, 12'd3900);
        chk("R7", "err_dup on repeat", err_dup, 1);
        send(2'd1, c[1]);
        chk("R7", "err_dup one cycle", err_dup, 0);
        send(2'd2, c[2]);
        send(2'd3, c[3]);
        expect_out("R7", c);
    endtask

    // Completion of one pixel and a duplicate of the next land in the same cycle.
    task automatic t_overlap();
        logic [11:0] a [4] = '{12'd3500, 12'd40, 12'd4, 12'd1};
        logic [11:0] b [4] = '{12'd4095, 12'd2222, 12'd19, 12'd2};
        longint v; int s;
        send(2'd0, a[0]); send(2'd1, a[1]); send(2'd2, a[2]); send(2'd3, a[3]);
        send(2'd1, b[1]);
        send(2'd1, 12'd7);
        model(a, sat_level, v, s);
        chk("R8", "out_valid with error", out_valid, 1);
        chk("R8", "out_value first pixel", out_value, v);
        chk("R7", "err_dup with output", err_dup, 1);
        send(2'd3, b[3]); send(2'd0, b[0]); send(2'd2, b[2]);
        expect_out("R8", b);
    endtask

    initial begin
        t_reset();
        t_select();
        t_order();
        t_threshold();
        t_gaps();
        t_dup();
        t_overlap();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5ns * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule